// File: doc/BRIEF.md
# BCD Time-of-Day Register Window

This block is the clock part of a byte-addressed non-volatile memory space. It occupies the eight highest byte addresses of that space and keeps calendar time in packed BCD. The eight registers are a control byte, seconds, minutes, hours, a weekday/century byte, day of month, month and two-digit year. A host reads and writes them one byte at a time. Every write to a time field passes a range check, and a value that fails the check is dropped. The general storage below the window is not part of this block.

An external one-second pulse advances the counters. The carry runs from seconds up to the year and follows the real month lengths, including leap years. Bit 7 of the seconds byte is a stop flag: while it is set the counters hold their value, and when it is cleared counting continues from the held value. A window write that arrives in the same cycle as a tick holds that tick back by one cycle, so a write never races with a carry.

Top module: `tod_regfile`

## Requirements
- R1: The window is the eight addresses whose bits [ADDR_W-1:3] are all ones. Bits [2:0] select the register: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year. A read returns the selected register combinationally in the same cycle. A read outside the window returns 8'hFF, and a write outside the window changes no register.
- R2: A control write stores (data AND NOT 8'hA0) OR 8'h90, and a control read returns the stored byte.
- R3: Seconds and minutes writes take data[6:0] and load it only if both nibbles are at most 9 and the value is at most 8'h59. An hours write takes data[5:0] under the same nibble rule with a limit of 8'h23. A rejected value leaves the field unchanged.
- R4: Every seconds write stores data[7] as the stop flag, even when the seconds value is rejected. A seconds read returns {stop, seconds}. While the flag is set, ticks are discarded. After the flag is cleared, counting continues from the frozen value.
- R5: A weekday/century write is always accepted. It stores data[6] as the century flag and data[2:0] as the weekday. A read returns {1'b0, century, 3'b000, weekday}.
- R6: A date write takes data[5:0] and is rejected when the value is zero or has a nibble above 9. A month write takes data[4:0] and is accepted only for BCD 01 to 12.
- R7: A year write takes the whole byte and is accepted only if both nibbles are at most 9.
- R8: After synchronous active-low reset the registers hold control 8'h90, time 00:00:00 with the stop flag clear, weekday 6, century 0, date 01, month 01 and year 00. No tick is pending.
- R9: On an applied tick, seconds advance by one. The carries are: seconds 59 to 00 into minutes, minutes 59 to 00 into hours, and hours 23 to 00 into the day. The day carry moves the weekday from 6 or 7 to 0 (otherwise +1) and advances the date. Month 12 to 01 carries into the year, and year 99 wraps to 00. The century flag never changes on a tick.
- R10: The date wraps to 01 and advances the month once it is at or above the month length. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year's binary value is a multiple of 4, and 28 days otherwise. All other months have 31 days.
- R11: A tick that coincides with any window write, accepted or rejected, is deferred. It is applied at the first following cycle without a window write. At most one tick is held back. A held tick is discarded if the stop flag is set when it would be applied.
- R12: An applied tick changes the registers at the clock edge that samples it, and the change is visible to reads in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The hardest states to reach from the ports are full carry cascades: year 99 to 00 at midnight on 31 December, and the end of February in leap and common years. The one-second pulse would need years of ticks to reach them. The bench uses accepted writes to load each field to one tick before the boundary and then applies one or two ticks. A tick coinciding with a write, and a tick while the stop flag is set, are produced by direct stimulus. They are also produced by a long pseudo-random mix of ticks, writes, rejected values and out-of-window accesses, and every cycle of that mix is checked against the behavioural model.

// File: rtl/tod_pkg.sv
// Shared types and BCD helpers for the time-of-day register window.
// Assumes packed BCD values with at most two digits per field.
package tod_pkg;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_SEC   = 3'd1,
        REG_MIN   = 3'd2,
        REG_HOUR  = 3'd3,
        REG_DAY   = 3'd4,
        REG_DATE  = 3'd5,
        REG_MONTH = 3'd6,
        REG_YEAR  = 3'd7
    } tod_reg_e;

    localparam logic [7:0] CTRL_CLR_MASK = 8'hA0;
    localparam logic [7:0] CTRL_SET_MASK = 8'h90;
    localparam logic [7:0] CTRL_RST_VAL  = 8'h90;
    localparam logic [2:0] WDAY_LAST     = 3'd6;
    localparam logic [2:0] WDAY_RST      = 3'd6;

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       cent;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
    } tod_time_t;

    // True when both nibbles are decimal digits.
    function automatic logic bcd_ok(input logic [7:0] v);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
    endfunction

    // Adds one to a two-digit BCD value (no upper wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last date of a month in BCD; leap test works on BCD year (10 mod 4 == 2).
    function automatic logic [7:0] month_last(input logic [4:0] mon,
                                              input logic [7:0] yr);
        logic [4:0] mod_sum;
        logic       leap;
        mod_sum = 5'({yr[7:4], 1'b0}) + 5'(yr[3:0]);
        leap    = (mod_sum[1:0] == 2'b00);
        case (mon)
            5'h02:                      return leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/tod_wr_filter.sv
// Write qualifier: masks the bus byte for the addressed field, applies the
// per-field range rule and raises a field enable only for accepted values.
// Assumes wr is already qualified by the window hit.
module tod_wr_filter
    import tod_pkg::*;
(
    input  logic       wr,
    input  logic [2:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] fld_we,
    output logic [7:0] fld_val,
    output logic       stop_we
);

    // Purpose: per-register masking and acceptance test.
    always_comb begin
        fld_we  = '0;
        fld_val = wdata;
        stop_we = wr && (idx == REG_SEC);
        case (idx)
            REG_CTRL: begin
                fld_val   = (wdata & ~CTRL_CLR_MASK) | CTRL_SET_MASK;
                fld_we[0] = wr;
            end
            REG_SEC: begin
                fld_val   = {1'b0, wdata[6:0]};
                fld_we[1] = wr && bcd_ok(fld_val) && (fld_val <= 8'h59);
            end
            REG_MIN: begin
                fld_val   = {1'b0, wdata[6:0]};
                fld_we[2] = wr && bcd_ok(fld_val) && (fld_val <= 8'h59);
            end
            REG_HOUR: begin
                fld_val   = {2'b00, wdata[5:0]};
                fld_we[3] = wr && bcd_ok(fld_val) && (fld_val <= 8'h23);
            end
            REG_DAY: begin
                fld_val   = {1'b0, wdata[6], 3'b000, wdata[2:0]};
                fld_we[4] = wr;
            end
            REG_DATE: begin
                fld_val   = {2'b00, wdata[5:0]};
                fld_we[5] = wr && bcd_ok(fld_val) && (fld_val != 8'h00);
            end
            REG_MONTH: begin
                fld_val   = {3'b000, wdata[4:0]};
                fld_we[6] = wr && bcd_ok(fld_val) && (fld_val >= 8'h01)
                            && (fld_val <= 8'h12);
            end
            default: begin
                fld_val   = wdata;
                fld_we[7] = wr && bcd_ok(wdata);
            end
        endcase
    end

endmodule

// File: rtl/tod_tick_sched.sv
// Tick scheduler: decides in which cycle a second is applied. A tick that
// meets a window write is held for one slot; ticks are dropped while stopped.
// Assumes sec_tick is a single-cycle pulse.
module tod_tick_sched (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic stopped,
    input  logic bus_wr,
    output logic adv
);

    logic pend_q;
    logic want;

    assign want = (sec_tick | pend_q) & ~stopped;
    assign adv  = want & ~bus_wr;

    // Purpose: remember one tick that collided with a window write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= want & bus_wr;
    end

endmodule

// File: rtl/tod_bcd_step.sv
// One BCD counter stage: advances cur by one when en is set and returns to
// LO once cur has reached HI; wrap flags that carry. Assumes W <= 8.
module tod_bcd_step
    import tod_pkg::*;
#(
    parameter int         W  = 7,
    parameter logic [7:0] LO = 8'h00,
    parameter logic [7:0] HI = 8'h59
) (
    input  logic [W-1:0] cur,
    input  logic         en,
    output logic [W-1:0] nxt,
    output logic         wrap
);

    logic [7:0] cur8;
    logic [7:0] inc8;
    logic       at_top;

    assign cur8   = 8'(cur);
    assign inc8   = bcd_inc(cur8);
    assign at_top = (cur8 >= HI);
    assign wrap   = en && at_top;

    // Purpose: next value of the stage.
    always_comb begin
        if (!en)
            nxt = cur;
        else if (at_top)
            nxt = W'(LO);
        else
            nxt = W'(inc8);
    end

endmodule

// File: rtl/tod_time_core.sv
// Time state: holds the control byte and all calendar fields, loads accepted
// writes and applies the carry chain on an advance. Assumes adv is never set
// in a cycle with a window write (the scheduler guarantees this).
module tod_time_core
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] fld_we,
    input  logic [7:0] fld_val,
    input  logic       stop_we,
    input  logic       stop_val,
    input  logic       adv,
    output tod_time_t  now,
    output logic [7:0] ctrl,
    output logic       year_roll
);

    tod_time_t  cur_q;
    logic [7:0] ctrl_q;

    logic [6:0] sec_n, min_n;
    logic [5:0] hour_n;
    logic [4:0] month_n;
    logic [7:0] year_n;
    logic       sec_wrap, min_wrap, day_adv, month_wrap;

    logic [7:0] last_date;
    logic [7:0] date_inc;
    logic       date_end;
    logic [5:0] date_n;
    logic [2:0] wday_n;

    tod_bcd_step #(.W(7), .LO(8'h00), .HI(8'h59)) u_sec (
        .cur(cur_q.sec), .en(adv), .nxt(sec_n), .wrap(sec_wrap));

    tod_bcd_step #(.W(7), .LO(8'h00), .HI(8'h59)) u_min (
        .cur(cur_q.min), .en(sec_wrap), .nxt(min_n), .wrap(min_wrap));

    tod_bcd_step #(.W(6), .LO(8'h00), .HI(8'h23)) u_hour (
        .cur(cur_q.hour), .en(min_wrap), .nxt(hour_n), .wrap(day_adv));

    assign last_date = month_last(cur_q.month, cur_q.year);
    assign date_inc  = bcd_inc({2'b00, cur_q.date});
    assign date_end  = ({2'b00, cur_q.date} >= last_date);

    // Purpose: date and weekday move on the day carry.
    always_comb begin
        date_n = cur_q.date;
        wday_n = cur_q.wday;
        if (day_adv) begin
            date_n = date_end ? 6'h01 : date_inc[5:0];
            wday_n = (cur_q.wday >= WDAY_LAST) ? 3'd0 : cur_q.wday + 3'd1;
        end
    end

    tod_bcd_step #(.W(5), .LO(8'h01), .HI(8'h12)) u_month (
        .cur(cur_q.month), .en(day_adv && date_end), .nxt(month_n),
        .wrap(month_wrap));

    tod_bcd_step #(.W(8), .LO(8'h00), .HI(8'h99)) u_year (
        .cur(cur_q.year), .en(month_wrap), .nxt(year_n), .wrap(year_roll));

    // Purpose: register update, write load has priority over the carry chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= CTRL_RST_VAL;
            cur_q.stop  <= 1'b0;
            cur_q.sec   <= 7'h00;
            cur_q.min   <= 7'h00;
            cur_q.hour  <= 6'h00;
            cur_q.cent  <= 1'b0;
            cur_q.wday  <= WDAY_RST;
            cur_q.date  <= 6'h01;
            cur_q.month <= 5'h01;
            cur_q.year  <= 8'h00;
        end else begin
            if (fld_we[0]) ctrl_q <= fld_val;
            if (stop_we)   cur_q.stop <= stop_val;
            cur_q.sec   <= fld_we[1] ? fld_val[6:0] : sec_n;
            cur_q.min   <= fld_we[2] ? fld_val[6:0] : min_n;
            cur_q.hour  <= fld_we[3] ? fld_val[5:0] : hour_n;
            if (fld_we[4]) begin
                cur_q.cent <= fld_val[6];
                cur_q.wday <= fld_val[2:0];
            end else begin
                cur_q.wday <= wday_n;
            end
            cur_q.date  <= fld_we[5] ? fld_val[5:0] : date_n;
            cur_q.month <= fld_we[6] ? fld_val[4:0] : month_n;
            cur_q.year  <= fld_we[7] ? fld_val : year_n;
        end
    end

    assign now  = cur_q;
    assign ctrl = ctrl_q;

endmodule

// File: rtl/tod_read_mux.sv
// Read path: assembles the byte image of the selected register; outside the
// window the bus floats high. Purely combinational.
module tod_read_mux
    import tod_pkg::*;
(
    input  logic       hit,
    input  logic [2:0] idx,
    input  tod_time_t  now,
    input  logic [7:0] ctrl,
    output logic [7:0] rdata
);

    // Purpose: select and pack the register image.
    always_comb begin
        if (!hit) begin
            rdata = 8'hFF;
        end else begin
            case (idx)
                REG_CTRL:  rdata = ctrl;
                REG_SEC:   rdata = {now.stop, now.sec};
                REG_MIN:   rdata = {1'b0, now.min};
                REG_HOUR:  rdata = {2'b00, now.hour};
                REG_DAY:   rdata = {1'b0, now.cent, 3'b000, now.wday};
                REG_DATE:  rdata = {2'b00, now.date};
                REG_MONTH: rdata = {3'b000, now.month};
                default:   rdata = now.year;
            endcase
        end
    end

endmodule

// File: rtl/tod_regfile.sv
// Top of the time-of-day window: decodes the top eight byte addresses of an
// ADDR_W-bit space, filters writes, schedules ticks and serves reads.
// Assumes a single-cycle byte bus and a one-cycle sec_tick pulse.
module tod_regfile
    import tod_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);

    localparam int TOP_W = ADDR_W - 3;

    logic             win_hit;
    logic             win_wr;
    logic [2:0]       idx;
    logic [TOP_W-1:0] top_bits;
    logic [7:0]       fld_we;
    logic [7:0]       fld_val;
    logic             stop_we;
    logic             adv;
    tod_time_t        now;
    logic [7:0]       ctrl;
    logic             year_roll;

    assign top_bits = bus_addr[ADDR_W-1:3];
    assign win_hit  = &top_bits;
    assign win_wr   = bus_we && win_hit;
    assign idx      = bus_addr[2:0];

    tod_wr_filter u_filter (
        .wr(win_wr), .idx(idx), .wdata(bus_wdata),
        .fld_we(fld_we), .fld_val(fld_val), .stop_we(stop_we));

    tod_tick_sched u_sched (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .stopped(now.stop), .bus_wr(win_wr), .adv(adv));

    tod_time_core u_core (
        .clk(clk), .rst_n(rst_n), .fld_we(fld_we), .fld_val(fld_val),
        .stop_we(stop_we), .stop_val(bus_wdata[7]), .adv(adv),
        .now(now), .ctrl(ctrl), .year_roll(year_roll));

    tod_read_mux u_rmux (
        .hit(win_hit), .idx(idx), .now(now), .ctrl(ctrl), .rdata(bus_rdata));

endmodule

// File: rtl/tod_regfile_chk.sv
// Property checker for tod_regfile, attached with bind below.
module tod_regfile_chk
    import tod_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       win_wr,
    input logic [2:0] idx,
    input logic [5:0] date_field,
    input tod_time_t  now,
    input logic [7:0] ctrl,
    input logic       year_roll
);

    AST_CTRL_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl & 8'hB0) == 8'h90); // R2

    AST_SEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_ok({1'b0, now.sec}) && (now.sec <= 7'h59)); // R3

    AST_MIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_ok({1'b0, now.min}) && (now.min <= 7'h59)); // R3

    AST_HOUR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_ok({2'b00, now.hour}) && (now.hour <= 6'h23)); // R3

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (now.stop && !win_wr) |=> $stable(now.sec)); // R4

    AST_CENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |=> $stable(now.cent)); // R5

    AST_MONTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_ok({3'b000, now.month}) && (now.month >= 5'h01)
        && (now.month <= 5'h12)); // R6

    AST_DATE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && idx == 3'd5 && date_field == 6'h00) |=> $stable(now.date)); // R6

    AST_YEAR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_ok(now.year)); // R7

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |=> ($stable(now.sec) ||
                     ({1'b0, now.sec} == (($past(now.sec) == 7'h59) ? 8'h00
                                          : bcd_inc({1'b0, $past(now.sec)}))))); // R9

    AST_WDAY_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |=> ($stable(now.wday) || now.hour == 6'h00)); // R9

    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        year_roll |=> (now.year == 8'h00)); // R9

endmodule

bind tod_regfile tod_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .idx(idx),
    .date_field(bus_wdata[5:0]), .now(now), .ctrl(ctrl),
    .year_roll(year_roll));

// File: tb/sim_tod_regfile.sv
// Bench for tod_regfile: behavioural calendar model in integers, compared
// against a bus read on every clock.
module sim_tod_regfile;

    localparam int AW = 13;
    localparam logic [AW-1:0] WBASE = 13'h1FF8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_tick = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = WBASE;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;

    always #2 clk = ~clk;

    tod_regfile #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    int n_chk = 0;
    int n_fail = 0;

    // Behavioural model state (binary values)
    int m_ctrl, m_stop, m_sec, m_min, m_hr, m_cent, m_wday;
    int m_date, m_mon, m_yr, m_pend;

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic bit is_bcd(input int v);
        return ((v & 15) <= 9) && ((v >> 4) <= 9);
    endfunction

    function automatic int from_bcd(input int v);
        return (v >> 4) * 10 + (v & 15);
    endfunction

    function automatic int mlen(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic void m_reset();
        m_ctrl = 8'h90; m_stop = 0; m_sec = 0; m_min = 0; m_hr = 0;
        m_cent = 0; m_wday = 6; m_date = 1; m_mon = 1; m_yr = 0; m_pend = 0;
    endfunction

    function automatic int m_read(input logic [AW-1:0] a);
        if (a[AW-1:3] != '1) return 8'hFF;
        case (a[2:0])
            3'd0: return m_ctrl;
            3'd1: return (m_stop << 7) | to_bcd(m_sec);
            3'd2: return to_bcd(m_min);
            3'd3: return to_bcd(m_hr);
            3'd4: return (m_cent << 6) | m_wday;
            3'd5: return to_bcd(m_date);
            3'd6: return to_bcd(m_mon);
            default: return to_bcd(m_yr);
        endcase
    endfunction

    function automatic void m_write(input int idx, input int d);
        int v;
        case (idx)
            0: m_ctrl = ((d & ~8'hA0) | 8'h90) & 8'hFF;
            1: begin
                m_stop = (d >> 7) & 1;
                v = d & 8'h7F;
                if (is_bcd(v) && from_bcd(v) <= 59) m_sec = from_bcd(v);
            end
            2: begin
                v = d & 8'h7F;
                if (is_bcd(v) && from_bcd(v) <= 59) m_min = from_bcd(v);
            end
            3: begin
                v = d & 8'h3F;
                if (is_bcd(v) && from_bcd(v) <= 23) m_hr = from_bcd(v);
            end
            4: begin
                m_cent = (d >> 6) & 1;
                m_wday = d & 7;
            end
            5: begin
                v = d & 8'h3F;
                if (is_bcd(v) && v != 0) m_date = from_bcd(v);
            end
            6: begin
                v = d & 8'h1F;
                if (is_bcd(v) && from_bcd(v) >= 1 && from_bcd(v) <= 12)
                    m_mon = from_bcd(v);
            end
            default: if (is_bcd(d)) m_yr = from_bcd(d);
        endcase
    endfunction

    function automatic void m_advance();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hr++;
        if (m_hr < 24) return;
        m_hr = 0;
        m_wday = (m_wday >= 6) ? 0 : m_wday + 1;
        if (m_date >= mlen(m_mon, m_yr)) begin
            m_date = 1; m_mon++;
            if (m_mon > 12) begin
                m_mon = 1;
                m_yr = (m_yr + 1) % 100;
            end
        end else begin
            m_date++;
        end
    endfunction

    function automatic void m_step(input bit t, input bit w,
                                   input logic [AW-1:0] a, input int d);
        bit wwin;
        bit want;
        wwin = w && (a[AW-1:3] == '1);
        want = (t || m_pend != 0) && (m_stop == 0);
        if (wwin) m_write(int'(a[2:0]), d);
        if (want && !wwin) m_advance();
        m_pend = (want && wwin) ? 1 : 0;
    endfunction

    task automatic check(input logic [7:0] got, input int exp,
                         input string tag, input logic [AW-1:0] a);
        n_chk++;
        if (got !== exp[7:0]) begin
            n_fail++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, a, got, exp[7:0]);
        end
    endtask

    // One bus cycle; reads are compared against the model before the edge.
    task automatic cyc(input bit t, input bit w, input logic [AW-1:0] a,
                       input int d, input string tag);
        @(negedge clk);
        sec_tick  = t;
        bus_we    = w;
        bus_addr  = a;
        bus_wdata = d[7:0];
        #1;
        if (!w) check(bus_rdata, m_read(a), tag, a);
        @(posedge clk);
        m_step(t, w, a, d);
    endtask

    task automatic wr(input int idx, input int d, input string tag);
        cyc(1'b0, 1'b1, WBASE + AW'(idx), d, tag);
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, WBASE + AW'(i), 0, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, WBASE + AW'(k % 8), 0, tag);
    endtask

    task automatic set_all(input int y, input int mo, input int dt,
                           input int h, input int mi, input int s);
        wr(7, y, "R7"); wr(6, mo, "R6"); wr(5, dt, "R6");
        wr(3, h, "R3"); wr(2, mi, "R3"); wr(1, s, "R4");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog got=timeout exp=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        m_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: reset image
        rd_all("R8");

        // R2: control encoding
        wr(0, 8'h00, "R2"); rd_all("R2");
        wr(0, 8'hFF, "R2"); rd_all("R2");
        wr(0, 8'h2A, "R2"); rd_all("R2");

        // R1: outside the window
        cyc(1'b0, 1'b1, 13'h0005, 8'h55, "R1");
        cyc(1'b0, 1'b1, 13'h1FF0, 8'h12, "R1");
        cyc(1'b0, 1'b0, 13'h0005, 0, "R1");
        cyc(1'b0, 1'b0, 13'h1FF7, 0, "R1");
        rd_all("R1");

        // R3: seconds, minutes, hours range checks
        wr(1, 8'h45, "R3"); wr(1, 8'h60, "R3"); wr(1, 8'h3A, "R3");
        wr(2, 8'h59, "R3"); wr(2, 8'h5A, "R3"); wr(2, 8'h7F, "R3");
        wr(3, 8'h23, "R3"); wr(3, 8'h24, "R3"); wr(3, 8'h92, "R3");
        rd_all("R3");

        // R5: weekday and century, then weekday wrap at midnight
        wr(4, 8'hFF, "R5"); rd_all("R5");
        wr(3, 8'h23, "R5"); wr(2, 8'h59, "R5"); wr(1, 8'h59, "R5");
        ticks(2, "R5"); rd_all("R5");
        wr(4, 8'h05, "R5"); rd_all("R5");

        // R6 / R7: date, month, year checks
        wr(5, 8'h00, "R6"); wr(5, 8'h1A, "R6"); wr(5, 8'h31, "R6");
        wr(5, 8'hC5, "R6");
        wr(6, 8'h00, "R6"); wr(6, 8'h13, "R6"); wr(6, 8'h0A, "R6");
        wr(6, 8'h12, "R6");
        wr(7, 8'h9A, "R7"); wr(7, 8'hA1, "R7"); wr(7, 8'h99, "R7");
        rd_all("R7");

        // R9: full cascade to a new century
        set_all(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58);
        ticks(2, "R9"); rd_all("R9");

        // R10: leap and common February, short month with oversized date
        set_all(8'h04, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        ticks(1, "R10"); rd_all("R10");
        wr(3, 8'h23, "R10"); wr(2, 8'h59, "R10"); wr(1, 8'h59, "R10");
        ticks(1, "R10"); rd_all("R10");
        set_all(8'h03, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        ticks(1, "R10"); rd_all("R10");
        set_all(8'h10, 8'h04, 8'h31, 8'h23, 8'h59, 8'h59);
        ticks(1, "R10"); rd_all("R10");

        // R4: stop freezes, rejected value still sets flag, resume
        wr(1, 8'h90, "R4"); ticks(5, "R4"); rd_all("R4");
        wr(1, 8'hFA, "R4"); ticks(3, "R4"); rd_all("R4");
        wr(1, 8'h10, "R4"); ticks(1, "R4"); rd_all("R4");

        // R11: tick meeting a write, accepted and rejected
        wr(1, 8'h20, "R11");
        cyc(1'b1, 1'b1, WBASE + 13'd2, 8'h07, "R11");
        cyc(1'b0, 1'b0, WBASE + 13'd1, 0, "R11");
        cyc(1'b0, 1'b0, WBASE + 13'd1, 0, "R11");
        cyc(1'b1, 1'b1, WBASE + 13'd6, 8'h00, "R11");
        cyc(1'b1, 1'b1, WBASE + 13'd6, 8'h00, "R11");
        cyc(1'b0, 1'b0, WBASE + 13'd1, 0, "R11");
        cyc(1'b0, 1'b0, WBASE + 13'd1, 0, "R11");
        cyc(1'b1, 1'b1, WBASE + 13'd1, 8'h85, "R11");
        rd_all("R11");
        wr(1, 8'h05, "R11"); rd_all("R11");

        // R12: one visible step per applied tick
        ticks(70, "R12");

        // Mixed pseudo-random traffic
        lfsr = 32'hACE1_2025;
        for (int c = 0; c < 4000; c++) begin
            logic [AW-1:0] a;
            int d;
            bit t, w;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            t = lfsr[0] | lfsr[1];
            w = (lfsr[4:2] == 3'b000);
            a = WBASE + AW'(lfsr[7:5]);
            if (lfsr[18:16] == 3'b000) a = AW'(lfsr[30:18]);
            d = int'(lfsr[15:8]);
            if (a[2:0] == 3'd1 && lfsr[20:19] != 2'b00) d = d & 8'h7F;
            cyc(t, w, a, d, "R9");
        end
        rd_all("R9");

        summary();
        $finish;
    end

endmodule